// File: doc/BRIEF.md
# SAR ADC Controller Register Block

This block is the software-facing register file of a multi-channel successive-approximation ADC controller. A host reaches it over a simple 32-bit APB-style bus. Each transfer has a setup phase and an access phase, and a write takes effect on the clock edge that closes the access phase. Two control words hold the start and soft-reset fields, the channel, the averaging count and the converter configuration. The block presents these to a conversion engine as plain configuration outputs.

Software starts a conversion by setting the start bit. The block then raises a request towards the engine and holds it until the engine acknowledges it. The engine later pulses a done strobe with a 12-bit result. The block captures the result and sets a polled end-of-conversion flag. On the same edge it sets a sticky interrupt status bit, which software clears by writing a one. The interrupt line is the status bit masked by an enable bit. A read-only version word completes the map.

Top module: `sarc_csr`

## Requirements
- R1: After reset the words read: control 1 (0x00) = 0x0000_0002, control 2 (0x04) = 0x0000_0720, status (0x08) = 0, data (0x0C) = 0, interrupt enable (0x10) = 0, interrupt status (0x14) = 0, version (0x20) = 0x8000_0008. After reset `irq` and `eng_req` are low.
- R2: Only implemented bits hold state. Control 1 keeps bits [2:0] and control 2 keeps bits [10:8] and [6:0]. Every other bit reads zero whatever was written, so writing all ones to control 2 reads back 0x0000_077F.
- R3: Control 2 drives the engine configuration. Bits [3:0] go to `eng_chan`, bits [6:4] to `eng_avg`, bit 8 to `eng_rate`, bit 9 to `eng_timing` and bit 10 to `eng_fmt`.
- R4: Writing control 1 with bit 0 set raises `eng_req` after the write edge. This needs a channel in 0..9 and bits [2:1] not equal to 2. `eng_req` stays high until a cycle with `eng_ack` high. On that edge the start bit clears itself, so `eng_req` falls and control 1 bit 0 reads 0.
- R5: A start written while channel 0xA..0xF is selected is dropped. `eng_req` stays low and control 1 bit 0 reads 0.
- R6: While control 1 bits [2:1] equal 2, `eng_hold` is high, `eng_req` is low, any start written is dropped and the end-of-conversion flag is cleared. Values 0, 1 and 3 mean normal operation.
- R7: Status bit 2 clears on the edge at which the engine accepts a start. It sets on the edge of an `eng_done` pulse.
- R8: On a done edge `eng_data` is captured, and the data word returns it in bits [11:0] with bits [31:12] zero, over the full range 0x000..0xFFF.
- R9: Interrupt status bit 0 sets on the same edge the end-of-conversion flag rises and then stays set. Writing it with bit 0 = 1 clears it and writing 0 has no effect. A set in the same cycle as a clearing write wins.
- R10: `irq` is high exactly when interrupt enable bit 0 and interrupt status bit 0 are both 1. With the enable at 0, the status still sets but `irq` stays low.
- R11: The version word ignores writes and always reads 0x8000_0008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed register, combinational |
| eng_req | output | 1 | Start request to the conversion engine |
| eng_ack | input | 1 | Engine accepts the request |
| eng_done | input | 1 | One-cycle conversion-complete strobe |
| eng_data | input | 12 | Conversion result, valid with `eng_done` |
| eng_chan | output | 4 | Selected analog channel |
| eng_avg | output | 3 | Averaging-count code |
| eng_fmt | output | 1 | Output-format select |
| eng_timing | output | 1 | First-output timing select |
| eng_rate | output | 1 | Conversion-rate select |
| eng_hold | output | 1 | Soft reset: engine held idle |
| irq | output | 1 | Masked interrupt |

## Verification
Each register takes one edge. A bus write lands on the edge that closes its access phase, and `eng_req`, `eng_hold`, the engine configuration outputs and the read word show the new value right after that edge. An acknowledge or done pulse acts on the one edge where it is high. From that edge, the start bit, the request, the end-of-conversion flag, the captured data, the interrupt status and `irq` all change together. The bench drives every input on the falling edge. It calls its checks only after the edge that should produce the effect, so every sample falls half a period away from any active edge. Reads are sampled during the access phase, since `prdata` is combinational.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int WORD_W  = 32;
    localparam int RES_W   = 12;
    localparam int CH_W    = 4;
    localparam int AVG_W   = 3;
    localparam int MAX_CH  = 9;
    localparam int SRST_W  = 2;

    localparam logic [7:0] OFF_CTL1   = 8'h00;
    localparam logic [7:0] OFF_CTL2   = 8'h04;
    localparam logic [7:0] OFF_STAT   = 8'h08;
    localparam logic [7:0] OFF_DATA   = 8'h0C;
    localparam logic [7:0] OFF_INTEN  = 8'h10;
    localparam logic [7:0] OFF_INTST  = 8'h14;
    localparam logic [7:0] OFF_VER    = 8'h20;

    localparam logic [SRST_W-1:0] SRST_ACTIVE = 2'd2;
    localparam logic [SRST_W-1:0] SRST_IDLE   = 2'd1;
    localparam int EOC_BIT = 2;

    typedef struct packed {
        logic [SRST_W-1:0] srst;
        logic              start;
    } ctl1_t;

    typedef struct packed {
        logic             fmt;
        logic             timing;
        logic             rate;
        logic [AVG_W-1:0] avg;
        logic [CH_W-1:0]  chan;
    } ctl2_t;

    localparam ctl2_t CTL2_RESET = '{fmt: 1'b1, timing: 1'b1, rate: 1'b1,
                                     avg: 3'd2, chan: 4'd0};

    function automatic logic chan_ok(input logic [CH_W-1:0] c);
        return c <= CH_W'(MAX_CH);
    endfunction

    function automatic logic [WORD_W-1:0] ctl1_word(input ctl1_t c);
        return {{(WORD_W-3){1'b0}}, c.srst, c.start};
    endfunction

    function automatic logic [WORD_W-1:0] ctl2_word(input ctl2_t c);
        return {{(WORD_W-11){1'b0}}, c.fmt, c.timing, c.rate, 1'b0, c.avg, c.chan};
    endfunction

    function automatic ctl2_t ctl2_from(input logic [10:0] w);
        ctl2_t c;
        c.fmt    = w[10];
        c.timing = w[9];
        c.rate   = w[8];
        c.avg    = w[6:4];
        c.chan   = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/sarc_ctl_regs.sv
module sarc_ctl_regs
    import sarc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctl1,
    input  logic        wr_ctl2,
    input  logic [10:0] wdata,
    input  logic        eng_ack,
    output ctl1_t       ctl1,
    output ctl2_t       ctl2,
    output logic        eng_req,
    output logic        hold
);

    logic chan_legal;

    assign chan_legal = chan_ok(ctl2.chan);
    assign hold       = (ctl1.srst == SRST_ACTIVE);
    assign eng_req    = ctl1.start & chan_legal & ~hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1 <= '{srst: SRST_IDLE, start: 1'b0};
            ctl2 <= CTL2_RESET;
        end else begin
            if (wr_ctl2) begin
                ctl2 <= ctl2_from(wdata);
            end
            if (wr_ctl1) begin
                ctl1.srst  <= wdata[2:1];
                ctl1.start <= wdata[0] & chan_legal & (wdata[2:1] != SRST_ACTIVE);
            end else if (hold || !chan_legal || (eng_req && eng_ack)) begin
                ctl1.start <= 1'b0;
            end
        end
    end

    // R4: an accepted request drops unless software rewrote control 1
    assert_start_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_ack && !wr_ctl1) |=> !eng_req);

    // R5: a start written on a reserved channel never produces a request
    assert_reserved_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl1 && !wr_ctl2 && !chan_ok(ctl2.chan)) |=> !eng_req);

    // R6: writing the active soft-reset code holds the engine next cycle
    assert_srst_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl1 && wdata[2:1] == SRST_ACTIVE) |=> (hold && !eng_req));

endmodule

// File: rtl/sarc_result.sv
module sarc_result
    import sarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             accept,
    input  logic             eng_done,
    input  logic [RES_W-1:0] eng_data,
    output logic             eoc,
    output logic [RES_W-1:0] result,
    output logic             eoc_rise
);

    assign eoc_rise = eng_done & ~hold & ~eoc;

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc    <= 1'b0;
            result <= '0;
        end else if (hold) begin
            eoc <= 1'b0;
        end else if (eng_done) begin
            eoc    <= 1'b1;
            result <= eng_data;
        end else if (accept) begin
            eoc <= 1'b0;
        end
    end

    // R7: the flag only rises after a done strobe
    assert_eoc_from_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> $past(eng_done));

    // R7: an accepted start with no done clears the flag
    assert_eoc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !eng_done) |=> !eoc);

    // R6: soft reset clears the flag
    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> !eoc);

endmodule

// File: rtl/sarc_irq.sv
module sarc_irq (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_st,
    input  logic wbit,
    input  logic set,
    output logic en,
    output logic st,
    output logic irq
);

    assign irq = en & st;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
            st <= 1'b0;
        end else begin
            if (wr_en) begin
                en <= wbit;
            end
            if (set) begin
                st <= 1'b1;
            end else if (wr_st && wbit) begin
                st <= 1'b0;
            end
        end
    end

    // R9: write-one clears when no new event arrives
    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_st && wbit && !set) |=> !st);

    // R9: status is sticky without a clearing write
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (st && !(wr_st && wbit)) |=> st);

    // R9: an event sets status regardless of a simultaneous clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set |=> st);

endmodule

// File: rtl/sarc_csr.sv
module sarc_csr
    import sarc_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h8000_0008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              eng_req,
    input  logic              eng_ack,
    input  logic              eng_done,
    input  logic [11:0]       eng_data,
    output logic [3:0]        eng_chan,
    output logic [2:0]        eng_avg,
    output logic              eng_fmt,
    output logic              eng_timing,
    output logic              eng_rate,
    output logic              eng_hold,
    output logic              irq
);

    logic             wr;
    logic             wr_ctl1, wr_ctl2, wr_inten, wr_intst;
    ctl1_t            ctl1;
    ctl2_t            ctl2;
    logic             eoc, eoc_rise;
    logic [RES_W-1:0] result;
    logic             int_en, int_st;
    logic             unused_bits;

    assign unused_bits = ^{pwdata[31:11], pwdata[7]};

    assign wr       = psel & penable & pwrite;
    assign wr_ctl1  = wr && (paddr == ADDR_W'(OFF_CTL1));
    assign wr_ctl2  = wr && (paddr == ADDR_W'(OFF_CTL2));
    assign wr_inten = wr && (paddr == ADDR_W'(OFF_INTEN));
    assign wr_intst = wr && (paddr == ADDR_W'(OFF_INTST));

    sarc_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl1 (wr_ctl1),
        .wr_ctl2 (wr_ctl2),
        .wdata   (pwdata[10:0]),
        .eng_ack (eng_ack),
        .ctl1    (ctl1),
        .ctl2    (ctl2),
        .eng_req (eng_req),
        .hold    (eng_hold)
    );

    sarc_result u_res (
        .clk      (clk),
        .rst      (rst),
        .hold     (eng_hold),
        .accept   (eng_req & eng_ack),
        .eng_done (eng_done),
        .eng_data (eng_data),
        .eoc      (eoc),
        .result   (result),
        .eoc_rise (eoc_rise)
    );

    sarc_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_inten),
        .wr_st (wr_intst),
        .wbit  (pwdata[0]),
        .set   (eoc_rise),
        .en    (int_en),
        .st    (int_st),
        .irq   (irq)
    );

    assign eng_chan   = ctl2.chan;
    assign eng_avg    = ctl2.avg;
    assign eng_fmt    = ctl2.fmt;
    assign eng_timing = ctl2.timing;
    assign eng_rate   = ctl2.rate;

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFF_CTL1))       prdata = ctl1_word(ctl1);
        else if (paddr == ADDR_W'(OFF_CTL2))  prdata = ctl2_word(ctl2);
        else if (paddr == ADDR_W'(OFF_STAT))  prdata[EOC_BIT] = eoc;
        else if (paddr == ADDR_W'(OFF_DATA))  prdata[RES_W-1:0] = result;
        else if (paddr == ADDR_W'(OFF_INTEN)) prdata[0] = int_en;
        else if (paddr == ADDR_W'(OFF_INTST)) prdata[0] = int_st;
        else if (paddr == ADDR_W'(OFF_VER))   prdata = VERSION;
    end

    // R9: interrupt status is set whenever the end-of-conversion flag rises
    assert_int_on_eoc_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> int_st);

    // R10: no interrupt while the enable bit is clear
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_inten && !pwdata[0]) |=> !irq);

endmodule

// File: tb/sarc_csr_bench.sv
module sarc_csr_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        eng_req, eng_ack, eng_done;
    logic [11:0] eng_data;
    logic [3:0]  eng_chan;
    logic [2:0]  eng_avg;
    logic        eng_fmt, eng_timing, eng_rate, eng_hold, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sarc_csr u_sarc_csr (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .eng_req(eng_req),
        .eng_ack(eng_ack), .eng_done(eng_done), .eng_data(eng_data),
        .eng_chan(eng_chan), .eng_avg(eng_avg), .eng_fmt(eng_fmt),
        .eng_timing(eng_timing), .eng_rate(eng_rate), .eng_hold(eng_hold), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic pulse_ack();
        @(negedge clk); eng_ack = 1'b1;
        @(posedge clk);
        @(negedge clk); eng_ack = 1'b0;
    endtask

    task automatic pulse_done(input logic [11:0] d);
        @(negedge clk); eng_done = 1'b1; eng_data = d;
        @(posedge clk);
        @(negedge clk); eng_done = 1'b0; eng_data = '0;
    endtask

    task automatic t_reset();
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        chk("R1", "eng_req", {31'd0, eng_req}, 32'd0);
        rd_chk("R1", 8'h00, 32'h0000_0002);
        rd_chk("R1", 8'h04, 32'h0000_0720);
        rd_chk("R1", 8'h08, 32'h0);
        rd_chk("R1", 8'h0C, 32'h0);
        rd_chk("R1", 8'h10, 32'h0);
        rd_chk("R1", 8'h14, 32'h0);
        rd_chk("R1", 8'h20, 32'h8000_0008);
    endtask

    task automatic t_fields();
        bus_wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h04, 32'h0000_077F);
        chk("R3", "cfg all ones", {20'd0, eng_fmt, eng_timing, eng_rate, 2'd0, eng_avg, eng_chan},
            {20'd0, 3'b111, 2'd0, 3'd7, 4'hF});
        bus_wr(8'h04, 32'h0000_0253);
        chk("R3", "cfg 0x253", {20'd0, eng_fmt, eng_timing, eng_rate, 2'd0, eng_avg, eng_chan},
            {20'd0, 3'b010, 2'd0, 3'd5, 4'h3});
        bus_wr(8'h20, 32'h0);
        rd_chk("R11", 8'h20, 32'h8000_0008);
        bus_wr(8'h00, 32'hFFFF_FFF8);
        rd_chk("R2", 8'h00, 32'h0000_0000);
        bus_wr(8'h00, 32'h0000_0002);
    endtask

    task automatic t_reserved_chan();
        bus_wr(8'h04, 32'h0000_072A);
        bus_wr(8'h00, 32'h0000_0003);
        chk("R5", "eng_req chan A", {31'd0, eng_req}, 32'd0);
        rd_chk("R5", 8'h00, 32'h0000_0002);
        bus_wr(8'h04, 32'h0000_072F);
        bus_wr(8'h00, 32'h0000_0003);
        chk("R5", "eng_req chan F", {31'd0, eng_req}, 32'd0);
    endtask

    task automatic t_convert();
        bus_wr(8'h04, 32'h0000_0729);
        bus_wr(8'h10, 32'h1);
        bus_wr(8'h00, 32'h0000_0003);
        chk("R4", "eng_req after start", {31'd0, eng_req}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R4", "eng_req held", {31'd0, eng_req}, 32'd1);
        pulse_ack();
        chk("R4", "eng_req after ack", {31'd0, eng_req}, 32'd0);
        rd_chk("R4", 8'h00, 32'h0000_0002);
        rd_chk("R7", 8'h08, 32'h0);
        pulse_done(12'hABC);
        chk("R9", "irq on done edge", {31'd0, irq}, 32'd1);
        rd_chk("R7", 8'h08, 32'h4);
        rd_chk("R8", 8'h0C, 32'h0000_0ABC);
        rd_chk("R9", 8'h14, 32'h1);
        chk("R10", "irq enabled", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_w1c();
        bus_wr(8'h14, 32'h0);
        rd_chk("R9", 8'h14, 32'h1);
        bus_wr(8'h14, 32'h1);
        rd_chk("R9", 8'h14, 32'h0);
        chk("R10", "irq after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_masked();
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h04, 32'h0000_0720);
        bus_wr(8'h00, 32'h0000_0003);
        pulse_ack();
        rd_chk("R7", 8'h08, 32'h0);
        pulse_done(12'hFFF);
        rd_chk("R8", 8'h0C, 32'h0000_0FFF);
        rd_chk("R10", 8'h14, 32'h1);
        chk("R10", "irq masked", {31'd0, irq}, 32'd0);
        bus_wr(8'h10, 32'h1);
        chk("R10", "irq unmasked", {31'd0, irq}, 32'd1);
        bus_wr(8'h14, 32'h1);
    endtask

    task automatic t_softreset();
        bus_wr(8'h00, 32'h0000_0004);
        chk("R6", "eng_hold", {31'd0, eng_hold}, 32'd1);
        rd_chk("R6", 8'h08, 32'h0);
        bus_wr(8'h00, 32'h0000_0005);
        chk("R6", "eng_req in hold", {31'd0, eng_req}, 32'd0);
        rd_chk("R6", 8'h00, 32'h0000_0004);
        bus_wr(8'h00, 32'h0000_0007);
        chk("R6", "eng_hold field 3", {31'd0, eng_hold}, 32'd0);
        chk("R6", "eng_req field 3", {31'd0, eng_req}, 32'd1);
        pulse_ack();
        bus_wr(8'h00, 32'h0000_0001);
        chk("R6", "eng_req field 0", {31'd0, eng_req}, 32'd1);
        pulse_ack();
    endtask

    task automatic t_set_vs_clear();
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h14; pwdata = 32'h1; penable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1; eng_done = 1'b1; eng_data = 12'h000;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; eng_done = 1'b0;
        rd_chk("R9", 8'h14, 32'h1);
        rd_chk("R8", 8'h0C, 32'h0);
        bus_wr(8'h14, 32'h1);
    endtask

    initial begin
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        eng_ack = 0; eng_done = 0; eng_data = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_fields();
        t_reserved_chan();
        t_convert();
        t_w1c();
        t_masked();
        t_softreset();
        t_set_vs_clear();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule